// File: doc/BRIEF.md
# PS/2 Host Controller

This block is the host end of a PS/2 link to a keyboard or a mouse. It samples the slow device clock and data lines in the system clock domain and assembles each device frame into a byte. The byte is presented with a strobe that lasts one cycle. In the other direction it takes a command byte from the user, claims the bus, and shifts the byte out under the device's clock. It then reports either completion or an error. Both bus lines are open drain: the block only ever pulls them low or lets them float, and external pull-ups make an idle line read high.

Every protocol interval is derived from one parameter, the system clock in MHz, multiplied by the interval in microseconds. There are three such intervals. The host holds the clock low for 101 µs before it releases the bus. It then allows 15 ms for the device to start clocking. Once clocking has begun, it allows 2 ms for the rest of the transfer to finish. The 2 ms figure also bounds the gap between bits of an incoming frame. A second parameter makes the block send the enable-reporting command 0xF4 by itself right after reset, which a mouse needs before it reports motion.

The transmitter is a state machine with these states:
- TX_IDLE leaves on a request to TX_INHIBIT.
- TX_INHIBIT holds the clock low, then moves to TX_REQ when its interval expires.
- TX_REQ releases the clock and pulls data low as the start bit. It moves to TX_BITS on the first device falling edge, or to TX_FAIL after 15 ms.
- TX_BITS presents one bit per falling edge and moves to TX_ACK after the tenth edge, or to TX_FAIL when the 2 ms window closes.
- TX_ACK goes to TX_DONE if data is low at the next falling edge, and to TX_FAIL otherwise or on timeout.
- TX_DONE and TX_FAIL each last one cycle and return to TX_IDLE.

The receiver is a state machine with these states:
- RX_IDLE moves to RX_SHIFT on a falling edge that carries a 0 start bit.
- RX_SHIFT collects ten bits and then moves to RX_CHECK. It falls back to RX_IDLE if the 2 ms gap expires or a transmission starts.
- RX_CHECK validates the frame and returns to RX_IDLE.

Top module: `ps2_host_ctrl`

## Requirements
- R1: While rst_n is 0 and right after it returns to 1, both bus lines are released (read high through the pull-ups), and rx_valid, tx_done and tx_err are 0.
- R2: A device frame consists of, in order, a 0 start bit, eight data bits with bit 0 first, a parity bit that makes the nine data-plus-parity bits contain an odd number of ones, and a 1 stop bit. Each bit is taken on a falling edge of the bus clock. A well-formed frame yields its data on rx_byte together with an rx_valid pulse exactly one system clock long.
- R3: A frame whose parity bit leaves an even number of ones produces no rx_valid pulse.
- R4: A frame whose stop bit is 0 produces no rx_valid pulse.
- R5: If more than CLK_MHZ*2000 cycles pass between two falling edges of an incoming frame, the partial frame is discarded, and the next complete frame is received correctly.
- R6: A tx_go pulse while idle makes the block pull the bus clock low for CLK_MHZ*101 cycles. It then releases the clock, with data already pulled low as the start bit.
- R7: After release, on each of the device's first ten falling clock edges the block presents the next bit: the eight data bits with bit 0 first, then odd parity, then a released (1) stop bit. If data is low at the eleventh falling edge, tx_done pulses for one cycle.
- R8: If no falling clock edge arrives within CLK_MHZ*15000 cycles of the clock release, tx_err pulses and both lines are released.
- R9: If the transfer has not completed within CLK_MHZ*2000 cycles of the first falling edge, tx_err pulses and both lines are released.
- R10: If data is high at the eleventh falling edge (no acknowledge), tx_err pulses and tx_done stays 0.
- R11: While a transmission is in progress, no rx_valid pulse is produced, including for the clock edges the block makes itself.
- R12: tx_go is ignored while a transmission is in progress. The byte sent is the one captured at the start, and no second transfer follows.
- R13: With MOUSE_INIT set, the block sends the command 0xF4 after reset without any tx_go.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ps2_clk | inout | 1 | Open-drain bus clock line |
| ps2_dat | inout | 1 | Open-drain bus data line |
| tx_byte | input | 8 | Command byte to send |
| tx_go | input | 1 | Single-cycle request to send tx_byte |
| rx_byte | output | 8 | Last byte received from the device |
| rx_valid | output | 1 | One-cycle strobe marking a new rx_byte |
| tx_done | output | 1 | One-cycle pulse: command sent and acknowledged |
| tx_err | output | 1 | One-cycle pulse: command aborted |

## Verification
The hardest situations to reach from the ports are the transmit error exits, because a well-behaved device never produces them. The bench's device model is therefore scripted to misbehave in three ways. It ignores the request entirely, which tests the 15 ms window. It stops clocking after three bits, which tests the 2 ms window. It clocks all eleven edges but never pulls data low, which tests the missing acknowledge. A partial incoming frame followed by a long silence shows that the receiver drops stale bits before it accepts the next frame.

// File: rtl/ps2_host_pkg.sv
package ps2_host_pkg;

    typedef enum logic [2:0] {
        TX_IDLE,
        TX_INHIBIT,
        TX_REQ,
        TX_BITS,
        TX_ACK,
        TX_DONE,
        TX_FAIL
    } tx_state_e;

    typedef enum logic [1:0] {
        RX_IDLE,
        RX_SHIFT,
        RX_CHECK
    } rx_state_e;

    // Bits that follow the start bit: 8 data, parity, stop
    localparam int unsigned FRAME_BITS = 10;

    function automatic int unsigned span_cycles(input int unsigned mhz, input int unsigned usec);
        return mhz * usec;
    endfunction

    // Parity bit that gives the data-plus-parity group an odd number of ones
    function automatic logic odd_par(input logic [7:0] d);
        return ~^d;
    endfunction

endpackage

// File: rtl/ps2_line_sync.sv
module ps2_line_sync #(
    parameter int unsigned WIDTH  = 2,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] raw,
    output logic [WIDTH-1:0] sync
);

    logic [STAGES-1:0][WIDTH-1:0] stage_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage_q <= '1;
        end else begin
            stage_q[0] <= raw;
            for (int s = 1; s < STAGES; s++) begin
                stage_q[s] <= stage_q[s-1];
            end
        end
    end

    assign sync = stage_q[STAGES-1];

endmodule

// File: rtl/ps2_rx_fsm.sv
module ps2_rx_fsm
    import ps2_host_pkg::*;
#(
    parameter int unsigned GAP_CYCLES = 100000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       enable,
    input  logic       clk_fall,
    input  logic       dat_s,
    output logic [7:0] rx_byte,
    output logic       rx_valid
);

    localparam int unsigned GW = $clog2(GAP_CYCLES + 1);
    localparam logic [GW-1:0] GAP_LAST = GW'(GAP_CYCLES - 1);
    localparam logic [3:0] LAST_BIT = 4'(FRAME_BITS - 1);

    rx_state_e state, state_n;
    logic [9:0]    shreg;
    logic [3:0]    cnt;
    logic [GW-1:0] gap;
    logic          frame_ok;

    // shreg[9] = stop, shreg[8] = parity, shreg[7:0] = data
    assign frame_ok = shreg[9] & (^shreg[8:0]);

    always_comb begin
        state_n = state;
        unique case (state)
            RX_IDLE: begin
                if (enable && clk_fall && !dat_s) state_n = RX_SHIFT;
            end
            RX_SHIFT: begin
                if (!enable) state_n = RX_IDLE;
                else if (clk_fall && cnt == LAST_BIT) state_n = RX_CHECK;
                else if (!clk_fall && gap == GAP_LAST) state_n = RX_IDLE;
            end
            RX_CHECK: state_n = RX_IDLE;
            default:  state_n = RX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= RX_IDLE;
            shreg <= '0;
            cnt   <= '0;
            gap   <= '0;
        end else begin
            state <= state_n;
            if (state == RX_SHIFT) begin
                if (clk_fall) begin
                    shreg <= {dat_s, shreg[9:1]};
                    cnt   <= cnt + 4'd1;
                    gap   <= '0;
                end else begin
                    gap <= gap + GW'(1);
                end
            end else begin
                cnt <= '0;
                gap <= '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_valid <= 1'b0;
            rx_byte  <= '0;
        end else begin
            rx_valid <= (state == RX_CHECK) && frame_ok && enable;
            if ((state == RX_CHECK) && frame_ok && enable) rx_byte <= shreg[7:0];
        end
    end

    // R2: the strobe never lasts more than one cycle
    a_r2_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    // R5: a partial frame never outlives the gap limit
    a_r5_gap_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (state == RX_SHIFT) |-> (gap <= GAP_LAST));

endmodule

// File: rtl/ps2_tx_fsm.sv
module ps2_tx_fsm
    import ps2_host_pkg::*;
#(
    parameter int unsigned T_INH      = 5050,
    parameter int unsigned T_REQ      = 750000,
    parameter int unsigned T_BIT      = 100000,
    parameter bit          MOUSE_INIT = 1'b0,
    parameter logic [7:0]  BOOT_CMD   = 8'hF4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tx_go,
    input  logic [7:0] tx_byte,
    input  logic       clk_fall,
    input  logic       dat_s,
    output logic       clk_low,
    output logic       dat_low,
    output logic       busy,
    output logic       tx_done,
    output logic       tx_err
);

    localparam int unsigned T_MAX_A = (T_REQ > T_BIT) ? T_REQ : T_BIT;
    localparam int unsigned T_MAX   = (T_MAX_A > T_INH) ? T_MAX_A : T_INH;
    localparam int unsigned TW      = $clog2(T_MAX + 1);
    localparam logic [TW-1:0] INH_LAST = TW'(T_INH - 1);
    localparam logic [TW-1:0] REQ_LAST = TW'(T_REQ - 1);
    localparam logic [TW-1:0] BIT_LAST = TW'(T_BIT - 1);
    localparam logic [3:0]    LAST_EDGE = 4'(FRAME_BITS - 1);

    tx_state_e state, state_n;
    logic [8:0]    shreg;
    logic [3:0]    cnt;
    logic [TW-1:0] tmr;
    logic          boot_pend;
    logic          launch;
    logic [7:0]    launch_byte;

    assign launch      = tx_go | boot_pend;
    assign launch_byte = boot_pend ? BOOT_CMD : tx_byte;
    assign busy        = (state != TX_IDLE);

    always_comb begin
        state_n = state;
        unique case (state)
            TX_IDLE: begin
                if (launch) state_n = TX_INHIBIT;
            end
            TX_INHIBIT: begin
                if (tmr == INH_LAST) state_n = TX_REQ;
            end
            TX_REQ: begin
                if (clk_fall) state_n = TX_BITS;
                else if (tmr == REQ_LAST) state_n = TX_FAIL;
            end
            TX_BITS: begin
                if (clk_fall && cnt == LAST_EDGE) state_n = TX_ACK;
                else if (tmr == BIT_LAST) state_n = TX_FAIL;
            end
            TX_ACK: begin
                if (clk_fall) state_n = dat_s ? TX_FAIL : TX_DONE;
                else if (tmr == BIT_LAST) state_n = TX_FAIL;
            end
            TX_DONE: state_n = TX_IDLE;
            TX_FAIL: state_n = TX_IDLE;
            default: state_n = TX_IDLE;
        endcase
    end

    // State register and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= TX_IDLE;
            shreg     <= '1;
            cnt       <= '0;
            tmr       <= '0;
            boot_pend <= MOUSE_INIT;
        end else begin
            state <= state_n;
            // The bit window runs on from TX_BITS through TX_ACK
            if (state == TX_IDLE || (state_n != state && state_n != TX_ACK)) tmr <= '0;
            else tmr <= tmr + TW'(1);

            if (state == TX_IDLE && launch) begin
                shreg     <= {odd_par(launch_byte), launch_byte};
                boot_pend <= 1'b0;
            end
            if ((state == TX_REQ || state == TX_BITS) && clk_fall) begin
                shreg <= {1'b1, shreg[8:1]};
                cnt   <= (state == TX_REQ) ? 4'd1 : cnt + 4'd1;
            end
        end
    end

    // Registered line drives and status pulses
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            clk_low <= 1'b0;
            dat_low <= 1'b0;
            tx_done <= 1'b0;
            tx_err  <= 1'b0;
        end else begin
            clk_low <= (state_n == TX_INHIBIT);
            unique case (state_n)
                TX_REQ:  dat_low <= 1'b1;
                TX_BITS: dat_low <= clk_fall ? ~shreg[0] : dat_low;
                default: dat_low <= 1'b0;
            endcase
            tx_done <= (state_n == TX_DONE);
            tx_err  <= (state_n == TX_FAIL);
        end
    end

    // R6: the clock is released only after the full inhibit interval
    a_r6_inhibit_len: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(clk_low) |-> ($past(tmr) == INH_LAST));

    // R8: the wait for the first device edge never exceeds its window
    a_r8_req_window: assert property (@(posedge clk) disable iff (!rst_n)
        (state == TX_REQ) |-> (tmr <= REQ_LAST));

    // R9: the bit transfer never exceeds its window
    a_r9_bit_window: assert property (@(posedge clk) disable iff (!rst_n)
        (state == TX_BITS || state == TX_ACK) |-> (tmr <= BIT_LAST));

    // R7: the data line is released while waiting for the acknowledge
    a_r7_ack_release: assert property (@(posedge clk) disable iff (!rst_n)
        (state == TX_ACK) |-> !dat_low);

    // R12: the captured command does not change during the inhibit phase
    a_r12_cmd_held: assert property (@(posedge clk) disable iff (!rst_n)
        (state == TX_INHIBIT && $past(state) == TX_INHIBIT) |-> $stable(shreg));

endmodule

// File: rtl/ps2_host_ctrl.sv
module ps2_host_ctrl
    import ps2_host_pkg::*;
#(
    parameter int unsigned CLK_MHZ    = 50,
    parameter bit          MOUSE_INIT = 1'b0
) (
    input  logic       clk,
    input  logic       rst_n,
    inout  wire        ps2_clk,
    inout  wire        ps2_dat,
    input  logic [7:0] tx_byte,
    input  logic       tx_go,
    output logic [7:0] rx_byte,
    output logic       rx_valid,
    output logic       tx_done,
    output logic       tx_err
);

    localparam int unsigned T_INH_CYC = span_cycles(CLK_MHZ, 101);
    localparam int unsigned T_REQ_CYC = span_cycles(CLK_MHZ, 15000);
    localparam int unsigned T_BIT_CYC = span_cycles(CLK_MHZ, 2000);

    logic [1:0] line_s;     // [0] clock, [1] data
    logic       clk_prev;
    logic       clk_fall;
    logic       drv_clk_low;
    logic       drv_dat_low;
    logic       tx_busy;

    ps2_line_sync #(
        .WIDTH  (2),
        .STAGES (2)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .raw   ({ps2_dat, ps2_clk}),
        .sync  (line_s)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) clk_prev <= 1'b1;
        else        clk_prev <= line_s[0];
    end

    assign clk_fall = clk_prev & ~line_s[0];

    ps2_rx_fsm #(
        .GAP_CYCLES (T_BIT_CYC)
    ) u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (~tx_busy),
        .clk_fall (clk_fall),
        .dat_s    (line_s[1]),
        .rx_byte  (rx_byte),
        .rx_valid (rx_valid)
    );

    ps2_tx_fsm #(
        .T_INH      (T_INH_CYC),
        .T_REQ      (T_REQ_CYC),
        .T_BIT      (T_BIT_CYC),
        .MOUSE_INIT (MOUSE_INIT),
        .BOOT_CMD   (8'hF4)
    ) u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .tx_go    (tx_go),
        .tx_byte  (tx_byte),
        .clk_fall (clk_fall),
        .dat_s    (line_s[1]),
        .clk_low  (drv_clk_low),
        .dat_low  (drv_dat_low),
        .busy     (tx_busy),
        .tx_done  (tx_done),
        .tx_err   (tx_err)
    );

    // Open drain: drive low or float
    assign ps2_clk = drv_clk_low ? 1'b0 : 1'bz;
    assign ps2_dat = drv_dat_low ? 1'b0 : 1'bz;

    // R11: the receiver stays silent while the transmitter owns the bus
    a_r11_rx_muted: assert property (@(posedge clk) disable iff (!rst_n)
        $past(tx_busy) |-> !rx_valid);

endmodule

// File: tb/test_ps2_host_ctrl.sv
module test_ps2_host_ctrl;

    localparam int unsigned MHZ   = 1;
    localparam int          HALF  = 8;
    localparam int          T_INH = 101 * MHZ;
    localparam int          T_REQ = 15000 * MHZ;
    localparam int          T_BIT = 2000 * MHZ;

    logic clk   = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    wire bc0, bd0, bc1, bd1;
    pullup (bc0);
    pullup (bd0);
    pullup (bc1);
    pullup (bd1);

    logic dev_cl [2] = '{1'b0, 1'b0};
    logic dev_dl [2] = '{1'b0, 1'b0};

    assign bc0 = dev_cl[0] ? 1'b0 : 1'bz;
    assign bd0 = dev_dl[0] ? 1'b0 : 1'bz;
    assign bc1 = dev_cl[1] ? 1'b0 : 1'bz;
    assign bd1 = dev_dl[1] ? 1'b0 : 1'bz;

    logic [7:0] tx_byte = 8'h00;
    logic       tx_go   = 1'b0;
    wire  [7:0] rx_byte, m_rx_byte;
    wire        rx_valid, tx_done, tx_err;
    wire        m_rx_valid, m_tx_done, m_tx_err;

    ps2_host_ctrl #(.CLK_MHZ(MHZ), .MOUSE_INIT(1'b0)) i_ps2_host_ctrl (
        .clk(clk), .rst_n(rst_n), .ps2_clk(bc0), .ps2_dat(bd0),
        .tx_byte(tx_byte), .tx_go(tx_go), .rx_byte(rx_byte),
        .rx_valid(rx_valid), .tx_done(tx_done), .tx_err(tx_err)
    );

    ps2_host_ctrl #(.CLK_MHZ(MHZ), .MOUSE_INIT(1'b1)) i_ps2_host_ctrl_mouse (
        .clk(clk), .rst_n(rst_n), .ps2_clk(bc1), .ps2_dat(bd1),
        .tx_byte(8'h00), .tx_go(1'b0), .rx_byte(m_rx_byte),
        .rx_valid(m_rx_valid), .tx_done(m_tx_done), .tx_err(m_tx_err)
    );

    int         rxv_cnt = 0;
    logic [7:0] rx_last = 8'h00;
    int         done_cnt = 0, err_cnt = 0, m_done_cnt = 0, m_err_cnt = 0;
    int         n_checks = 0, n_fail = 0;
    bit         finished = 1'b0;

    always @(negedge clk) begin
        if (rx_valid) begin rxv_cnt++; rx_last = rx_byte; end
        if (tx_done)   done_cnt++;
        if (tx_err)    err_cnt++;
        if (m_tx_done) m_done_cnt++;
        if (m_tx_err)  m_err_cnt++;
    end

    function automatic logic lc(input int u);
        return (u == 0) ? bc0 : bc1;
    endfunction

    function automatic logic ld(input int u);
        return (u == 0) ? bd0 : bd1;
    endfunction

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input bit ok, input string req, input string what, input int act, input int expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    // Device-to-host frame; nbits < 11 sends a truncated frame
    task automatic dev_send(input int u, input logic [7:0] b, input bit bad_par,
                            input bit bad_stop, input int nbits);
        logic [10:0] fr;
        fr = {~bad_stop, (~^b) ^ bad_par, b, 1'b0};
        for (int i = 0; i < nbits; i++) begin
            dev_dl[u] = ~fr[i];
            tick(HALF / 2);
            dev_cl[u] = 1'b1;
            tick(HALF);
            dev_cl[u] = 1'b0;
            tick(HALF / 2);
        end
        dev_dl[u] = 1'b0;
        tick(HALF);
    endtask

    // Wait for the host's inhibit, measure it, report data level on release
    task automatic dev_wait_req(input int u, output int low_cyc, output bit dat_low_seen);
        low_cyc = 0;
        while (lc(u) == 1'b1) tick(1);
        while (lc(u) == 1'b0) begin low_cyc++; tick(1); end
        dat_low_seen = (ld(u) == 1'b0);
    endtask

    // Clock host-to-device bits; ack_mode 0 none, 1 proper ack, 2 edge without ack
    task automatic dev_recv(input int u, input int edges, input int ack_mode, output logic [9:0] got);
        got = '0;
        tick(HALF);
        for (int i = 0; i < edges; i++) begin
            dev_cl[u] = 1'b1;
            tick(HALF);
            dev_cl[u] = 1'b0;
            tick(HALF);
            got[i] = ld(u);
        end
        if (ack_mode != 0) begin
            if (ack_mode == 1) dev_dl[u] = 1'b1;
            tick(2);
            dev_cl[u] = 1'b1;
            tick(HALF);
            dev_cl[u] = 1'b0;
            tick(HALF / 2);
            dev_dl[u] = 1'b0;
            tick(HALF);
        end
    endtask

    task automatic host_cmd(input logic [7:0] v);
        tx_byte = v;
        tx_go   = 1'b1;
        tick(1);
        tx_go   = 1'b0;
    endtask

    task automatic tx_round(input logic [7:0] v);
        int         r0, d0, e0, low;
        bit         dl;
        logic [9:0] got;
        r0 = rxv_cnt; d0 = done_cnt; e0 = err_cnt;
        host_cmd(v);
        dev_wait_req(0, low, dl);
        check(low >= T_INH && low <= T_INH + 1, "R6", "inhibit length", low, T_INH);
        check(dl, "R6", "start bit low on release", int'(dl), 1);
        dev_recv(0, 10, 1, got);
        tick(4);
        check(got[7:0] == v, "R7", "data bits", int'(got[7:0]), int'(v));
        check(got[8] == ~^v, "R7", "parity bit", int'(got[8]), int'(~^v));
        check(got[9] == 1'b1, "R7", "stop bit", int'(got[9]), 1);
        check(done_cnt == d0 + 1 && err_cnt == e0, "R7", "tx_done pulses", done_cnt - d0, 1);
        check(rxv_cnt == r0, "R11", "rx strobes during transmit", rxv_cnt - r0, 0);
    endtask

    initial begin : main
        int         c0, e0, d0, low, lows;
        bit         dl;
        logic [9:0] got;

        tick(5);
        check(bc0 == 1'b1 && bd0 == 1'b1, "R1", "lines in reset", int'({bc0, bd0}), 3);
        rst_n = 1'b1;
        tick(3);
        check(bc0 == 1'b1 && bd0 == 1'b1, "R1", "lines after reset", int'({bc0, bd0}), 3);
        check(!rx_valid && !tx_done && !tx_err, "R1", "strobes after reset",
              int'({rx_valid, tx_done, tx_err}), 0);

        // R13: mouse variant boots with 0xF4
        dev_wait_req(1, low, dl);
        dev_recv(1, 10, 1, got);
        tick(4);
        check(got[7:0] == 8'hF4, "R13", "boot command", int'(got[7:0]), 8'hF4);
        check(got[8] == ~^8'hF4, "R13", "boot parity", int'(got[8]), int'(~^8'hF4));
        check(m_done_cnt == 1 && m_err_cnt == 0, "R13", "boot done", m_done_cnt, 1);

        // R2: every byte value
        for (int b = 0; b < 256; b++) begin
            c0 = rxv_cnt;
            dev_send(0, 8'(b), 1'b0, 1'b0, 11);
            tick(4);
            check(rxv_cnt == c0 + 1, "R2", "strobe count", rxv_cnt - c0, 1);
            check(rx_last == 8'(b), "R2", "received byte", int'(rx_last), b);
        end

        // R3, R4: malformed frames dropped
        c0 = rxv_cnt;
        dev_send(0, 8'h5A, 1'b1, 1'b0, 11);
        tick(4);
        check(rxv_cnt == c0, "R3", "bad parity strobes", rxv_cnt - c0, 0);
        dev_send(0, 8'hC3, 1'b0, 1'b1, 11);
        tick(4);
        check(rxv_cnt == c0, "R4", "bad stop strobes", rxv_cnt - c0, 0);
        dev_send(0, 8'hA5, 1'b0, 1'b0, 11);
        tick(4);
        check(rxv_cnt == c0 + 1 && rx_last == 8'hA5, "R4", "recovery byte", int'(rx_last), 8'hA5);

        // R5: partial frame then long silence
        c0 = rxv_cnt;
        dev_send(0, 8'hFF, 1'b0, 1'b0, 5);
        tick(T_BIT + 100);
        dev_send(0, 8'h3C, 1'b0, 1'b0, 11);
        tick(4);
        check(rxv_cnt == c0 + 1, "R5", "strobes after gap", rxv_cnt - c0, 1);
        check(rx_last == 8'h3C, "R5", "byte after gap", int'(rx_last), 8'h3C);

        // R6, R7, R11: transmit sweep
        for (int v = 0; v < 256; v += 7) tx_round(8'(v));
        tx_round(8'hFF);

        // R12: second request during a transfer
        d0 = done_cnt;
        host_cmd(8'h12);
        tick(20);
        host_cmd(8'h99);
        dev_wait_req(0, low, dl);
        dev_recv(0, 10, 1, got);
        tick(4);
        check(got[7:0] == 8'h12, "R12", "byte sent", int'(got[7:0]), 8'h12);
        lows = 0;
        for (int i = 0; i < 300; i++) begin
            if (bc0 == 1'b0) lows++;
            tick(1);
        end
        check(lows == 0, "R12", "clock low cycles after done", lows, 0);
        check(done_cnt == d0 + 1, "R12", "tx_done count", done_cnt - d0, 1);

        // R8: device never answers
        e0 = err_cnt; d0 = done_cnt;
        host_cmd(8'h55);
        tick(T_INH + T_REQ + 20);
        check(err_cnt == e0 + 1, "R8", "tx_err count", err_cnt - e0, 1);
        check(done_cnt == d0, "R8", "tx_done count", done_cnt - d0, 0);
        check(bc0 == 1'b1 && bd0 == 1'b1, "R8", "lines released", int'({bc0, bd0}), 3);

        // R9: device stalls after three edges
        e0 = err_cnt;
        host_cmd(8'h66);
        dev_wait_req(0, low, dl);
        dev_recv(0, 3, 0, got);
        tick(T_BIT + 20);
        check(err_cnt == e0 + 1, "R9", "tx_err count", err_cnt - e0, 1);
        check(bc0 == 1'b1 && bd0 == 1'b1, "R9", "lines released", int'({bc0, bd0}), 3);

        // R10: no acknowledge
        e0 = err_cnt; d0 = done_cnt;
        host_cmd(8'h77);
        dev_wait_req(0, low, dl);
        dev_recv(0, 10, 2, got);
        tick(5);
        check(err_cnt == e0 + 1, "R10", "tx_err count", err_cnt - e0, 1);
        check(done_cnt == d0, "R10", "tx_done count", done_cnt - d0, 0);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin : watchdog
        repeat (190000) @(negedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog (all requirements): actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule